// File: doc/BRIEF.md
# Configuration Strap Capture and Test-Mode Controller

This block captures the board-level configuration straps of a clock generator once, at the moment the supply is declared good, and holds them until the next power cycle. The captured frequency-select code is decoded into the processor clock setting. The decoded value, the raw code and the output-role strap are presented for readback. The fixed source-clock and bus-clock settings are reported beside them.

The block also owns test mode. Test mode can be entered by a strap: the top frequency-select pin is driven to its extended high level at capture time. It can also be entered by a software entry bit. Once entered, test mode cannot be left until the block is reset, which models a power cycle. While in test mode, all clock outputs are either tri-stated or all carry the reference clock divided by a parameterised ratio. When entry came from the strap only, a live pin chooses between these two styles. When the software entry bit is set, a software style bit chooses and the pin is ignored.

The voltage-level detection of the extended high level lies outside the block. It arrives as a digital flag. The block runs on the reference clock with a synchronous active-low reset.

Top module: `strap_testmode_ctrl`

## Requirements
- R1: While and after reset, until straps are captured: straps_valid=0, fs_code=000, role_latched=0, cpu_freq=0, reserved_code=0, test_active=0, test_by_hw=0, out_mode=0 (normal) and refn_clk=0.
- R2: At the first rising clock edge after reset where pwrgd_n is 0, the block captures the straps and straps_valid becomes 1. The captured code is fs_code bit 2 = fs_c_in, bit 1 = fs_b_in, bit 0 = fs_a_in. After that, changes on the strap pins, on fs_c_hi or on pwrgd_n leave the captured values unchanged until reset.
- R3: cpu_freq is given in units of 10 kHz, decoded from fs_code as follows: 000→26666, 001→13333, 010→20000, 011→16666, 100→33333, 101→10000, 110→40000. src_freq always reads 10000 and pci_freq always reads 3333.
- R4: Code 111 is reserved: reserved_code=1 and cpu_freq falls back to 10000.
- R5: If fs_c_hi is 1 at capture, test_active and test_by_hw become 1 at the same edge. In that case fs_code bit 2 reads 0 and the decode uses {0, fs_b_in, fs_a_in}.
- R6: In test mode entered by strap only, out_mode follows test_pin without a register stage: 0 gives out_mode=1 (high impedance) and 1 gives out_mode=2 (REF/N). The software style bit has no effect while the software entry bit is 0.
- R7: A write (sw_wr=1) with sw_wr_entry=1 sets the software entry bit at that edge, and test_active reads 1 after it. While that bit is set, out_mode comes only from the software style bit: 0 gives 1 (high impedance), 1 gives 2 (REF/N). This holds also when the strap entered test mode, and test_pin is then ignored. Every write loads the style bit from sw_wr_style. Both bits are 0 after reset.
- R8: Test mode is sticky. Writing sw_wr_entry=0, toggling pwrgd_n or changing the pins never clears test_active; only rst_n does.
- R9: While out_mode=2, refn_clk is a periodic signal with a period of REFN_DIV clock cycles, high for REFN_DIV/2 cycles of each period. refn_clk is 0 in every cycle where out_mode is not 2.
- R10: role_latched holds the role_strap value captured at the edge given in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset (power cycle) |
| pwrgd_n | input | 1 | Active-low power-good; capture trigger |
| fs_a_in | input | 1 | Frequency-select strap, code bit 0 |
| fs_b_in | input | 1 | Frequency-select strap, code bit 1 |
| fs_c_in | input | 1 | Frequency-select strap, code bit 2 |
| fs_c_hi | input | 1 | Top select pin is at its extended high level |
| role_strap | input | 1 | Output-role strap for the shared pair |
| test_pin | input | 1 | Live style pin for strap-entered test mode |
| sw_wr | input | 1 | Write strobe for the two software test bits |
| sw_wr_entry | input | 1 | Software test entry value (sets only) |
| sw_wr_style | input | 1 | Software style value: 0 high-Z, 1 REF/N |
| straps_valid | output | 1 | Straps captured |
| fs_code | output | 3 | Captured frequency-select code |
| role_latched | output | 1 | Captured output-role strap |
| cpu_freq | output | 16 | Processor clock setting, 10 kHz units |
| src_freq | output | 16 | Source clock setting, 10 kHz units |
| pci_freq | output | 16 | Bus clock setting, 10 kHz units |
| reserved_code | output | 1 | Captured code is the reserved one |
| test_active | output | 1 | Test mode entered |
| test_by_hw | output | 1 | Test mode entered by strap |
| out_mode | output | 2 | 0 normal, 1 all high impedance, 2 all REF/N |
| refn_clk | output | 1 | Divided reference clock |

## Verification
A wrong capture shows up on fs_code, role_latched and cpu_freq at the first sample after the power-good edge. Corrupted held state shows once pins or power-good move afterwards. A lost or cleared test-mode bit shows at once on test_active and out_mode, because the style decision is combinational from the stored bits and the live pin. A wrong divider count shows on refn_clk within two periods, as a wrong high count or wrong spacing between rising edges.

// File: rtl/strap_pkg.sv
// Shared types and the frequency decode for the strap controller.
// Assumes a 3-bit frequency-select code and frequencies in 10 kHz units.
package strap_pkg;
    localparam int FS_W   = 3;
    localparam int FREQ_W = 16;

    localparam logic [FREQ_W-1:0] SRC_SETTING = 16'd10000;
    localparam logic [FREQ_W-1:0] PCI_SETTING = 16'd3333;
    localparam logic [FREQ_W-1:0] CPU_DEFAULT = 16'd10000;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_HIZ    = 2'd1,
        MODE_REFN   = 2'd2
    } out_mode_e;

    // Maps a select code to the processor clock setting; 111 is reserved.
    function automatic logic [FREQ_W-1:0] cpu_setting(input logic [FS_W-1:0] code);
        logic [FREQ_W-1:0] f;
        case (code)
            3'b000:  f = 16'd26666;
            3'b001:  f = 16'd13333;
            3'b010:  f = 16'd20000;
            3'b011:  f = 16'd16666;
            3'b100:  f = 16'd33333;
            3'b101:  f = 16'd10000;
            3'b110:  f = 16'd40000;
            default: f = CPU_DEFAULT;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/strap_capture.sv
// Captures the straps once, at the first clock with power-good asserted.
// Assumes pins are already synchronous to clk; values hold until reset.
module strap_capture
    import strap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwrgd_n,
    input  logic [FS_W-1:0] fs_pins,
    input  logic            fs_top_hi,
    input  logic            role_pin,
    output logic            captured,
    output logic [FS_W-1:0] code_q,
    output logic            role_q,
    output logic            hw_test_q
);
    logic take;
    logic [FS_W-1:0] code_in;

    // Capture fires only once per reset.
    assign take = !captured && !pwrgd_n;

    // An extended-level top pin is a test request, not a select bit.
    always_comb begin
        code_in = fs_pins;
        code_in[FS_W-1] = fs_pins[FS_W-1] & ~fs_top_hi;
    end

    // Holds the captured strap values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            captured  <= 1'b0;
            code_q    <= '0;
            role_q    <= 1'b0;
            hw_test_q <= 1'b0;
        end else if (take) begin
            captured  <= 1'b1;
            code_q    <= code_in;
            role_q    <= role_pin;
            hw_test_q <= fs_top_hi;
        end
    end
endmodule

// File: rtl/freq_decode.sv
// Decodes the captured select code into clock settings.
// Assumes outputs are meaningful only after capture; zero before it.
module freq_decode
    import strap_pkg::*;
(
    input  logic              valid,
    input  logic [FS_W-1:0]   code,
    output logic [FREQ_W-1:0] cpu_f,
    output logic [FREQ_W-1:0] src_f,
    output logic [FREQ_W-1:0] pci_f,
    output logic              reserved
);
    localparam logic [FS_W-1:0] RESERVED_CODE = '1;

    // Table lookup gated by capture state.
    always_comb begin
        cpu_f    = valid ? cpu_setting(code) : '0;
        reserved = valid && (code == RESERVED_CODE);
    end

    assign src_f = SRC_SETTING;
    assign pci_f = PCI_SETTING;
endmodule

// File: rtl/test_mode_ctrl.sv
// Holds the software test bits and picks the output style.
// Assumes the strap request is already captured; entry is sticky to reset.
module test_mode_ctrl
    import strap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hw_test,
    input  logic      style_pin,
    input  logic      wr,
    input  logic      wr_entry,
    input  logic      wr_style,
    output logic      active,
    output out_mode_e mode
);
    logic sw_entry_q;
    logic sw_style_q;

    // Entry bit only ever sets; the style bit follows each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_entry_q <= 1'b0;
            sw_style_q <= 1'b0;
        end else if (wr) begin
            sw_entry_q <= sw_entry_q | wr_entry;
            sw_style_q <= wr_style;
        end
    end

    assign active = sw_entry_q | hw_test;

    // Software entry owns the style; otherwise the live pin does.
    always_comb begin
        if (sw_entry_q)
            mode = sw_style_q ? MODE_REFN : MODE_HIZ;
        else if (hw_test)
            mode = style_pin ? MODE_REFN : MODE_HIZ;
        else
            mode = MODE_NORMAL;
    end
endmodule

// File: rtl/refn_divider.sv
// Divides the reference clock by DIV while enabled.
// Assumes DIV >= 2; the output is high for DIV/2 cycles of each period.
module refn_divider #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic div_out
);
    localparam int CNT_W = (DIV < 2) ? 1 : $clog2(DIV);
    localparam int HIGH  = DIV / 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic running;

    // Counter restarts from zero on every entry into the enabled state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else begin
            running <= enable;
            if (!running || !enable || cnt == LAST)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    assign div_out = enable && running && (cnt < CNT_W'(HIGH));
endmodule

// File: rtl/strap_testmode_ctrl.sv
// Top: strap capture, frequency decode, sticky test mode and REF/N divider.
// Assumes one reference clock domain and rst_n as the power-cycle event.
module strap_testmode_ctrl
    import strap_pkg::*;
#(
    parameter int REFN_DIV = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrgd_n,
    input  logic              fs_a_in,
    input  logic              fs_b_in,
    input  logic              fs_c_in,
    input  logic              fs_c_hi,
    input  logic              role_strap,
    input  logic              test_pin,
    input  logic              sw_wr,
    input  logic              sw_wr_entry,
    input  logic              sw_wr_style,
    output logic              straps_valid,
    output logic [2:0]        fs_code,
    output logic              role_latched,
    output logic [15:0]       cpu_freq,
    output logic [15:0]       src_freq,
    output logic [15:0]       pci_freq,
    output logic              reserved_code,
    output logic              test_active,
    output logic              test_by_hw,
    output logic [1:0]        out_mode,
    output logic              refn_clk
);
    out_mode_e mode;

    strap_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwrgd_n   (pwrgd_n),
        .fs_pins   ({fs_c_in, fs_b_in, fs_a_in}),
        .fs_top_hi (fs_c_hi),
        .role_pin  (role_strap),
        .captured  (straps_valid),
        .code_q    (fs_code),
        .role_q    (role_latched),
        .hw_test_q (test_by_hw)
    );

    freq_decode u_dec (
        .valid    (straps_valid),
        .code     (fs_code),
        .cpu_f    (cpu_freq),
        .src_f    (src_freq),
        .pci_f    (pci_freq),
        .reserved (reserved_code)
    );

    test_mode_ctrl u_tm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_test   (test_by_hw),
        .style_pin (test_pin),
        .wr        (sw_wr),
        .wr_entry  (sw_wr_entry),
        .wr_style  (sw_wr_style),
        .active    (test_active),
        .mode      (mode)
    );

    refn_divider #(.DIV(REFN_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (mode == MODE_REFN),
        .div_out (refn_clk)
    );

    assign out_mode = mode;
endmodule

// File: rtl/strap_testmode_ctrl_chk.sv
// Property checker for the strap controller, bound to the top module.
// Assumes only top-level ports are observed.
module strap_testmode_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        straps_valid,
    input logic [2:0]  fs_code,
    input logic        role_latched,
    input logic [15:0] cpu_freq,
    input logic        reserved_code,
    input logic        test_active,
    input logic        test_by_hw,
    input logic [1:0]  out_mode,
    input logic        refn_clk
);
    p_idle_before_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !straps_valid |-> (cpu_freq == 16'd0 && !reserved_code && !test_by_hw));

    p_capture_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        straps_valid |=> (straps_valid && $stable(fs_code)));

    p_role_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        straps_valid |=> $stable(role_latched));

    p_reserved_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reserved_code |-> (cpu_freq == 16'd10000));

    p_hw_top_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        test_by_hw |-> (fs_code[2] == 1'b0 && test_active));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        test_active |=> test_active);

    p_mode_needs_test_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode != 2'd0) |-> (test_active && out_mode != 2'd3));

    p_refn_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode != 2'd2) |-> !refn_clk);
endmodule

bind strap_testmode_ctrl strap_testmode_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .straps_valid  (straps_valid),
    .fs_code       (fs_code),
    .role_latched  (role_latched),
    .cpu_freq      (cpu_freq),
    .reserved_code (reserved_code),
    .test_active   (test_active),
    .test_by_hw    (test_by_hw),
    .out_mode      (out_mode),
    .refn_clk      (refn_clk)
);

// File: tb/strap_testmode_ctrl_test.sv
module strap_testmode_ctrl_test;
    localparam int N = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwrgd_n = 1'b1;
    logic fs_a_in = 1'b0, fs_b_in = 1'b0, fs_c_in = 1'b0, fs_c_hi = 1'b0;
    logic role_strap = 1'b0, test_pin = 1'b0;
    logic sw_wr = 1'b0, sw_wr_entry = 1'b0, sw_wr_style = 1'b0;
    logic straps_valid, role_latched, reserved_code, test_active, test_by_hw, refn_clk;
    logic [2:0] fs_code;
    logic [15:0] cpu_freq, src_freq, pci_freq;
    logic [1:0] out_mode;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    strap_testmode_ctrl #(.REFN_DIV(N)) uut (
        .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n),
        .fs_a_in(fs_a_in), .fs_b_in(fs_b_in), .fs_c_in(fs_c_in), .fs_c_hi(fs_c_hi),
        .role_strap(role_strap), .test_pin(test_pin),
        .sw_wr(sw_wr), .sw_wr_entry(sw_wr_entry), .sw_wr_style(sw_wr_style),
        .straps_valid(straps_valid), .fs_code(fs_code), .role_latched(role_latched),
        .cpu_freq(cpu_freq), .src_freq(src_freq), .pci_freq(pci_freq),
        .reserved_code(reserved_code), .test_active(test_active), .test_by_hw(test_by_hw),
        .out_mode(out_mode), .refn_clk(refn_clk)
    );

    function automatic int exp_cpu(input int code);
        case (code)
            0: return 26666;  1: return 13333;  2: return 20000;  3: return 16666;
            4: return 33333;  5: return 10000;  6: return 40000;  default: return 10000;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pwrgd_n = 1'b1; sw_wr = 1'b0; sw_wr_entry = 1'b0; sw_wr_style = 1'b0;
        fs_c_hi = 1'b0; test_pin = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic capture(input logic [2:0] code, input logic hi, input logic role);
        @(negedge clk);
        {fs_c_in, fs_b_in, fs_a_in} = code; fs_c_hi = hi; role_strap = role; pwrgd_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic sw_write(input logic entry, input logic style);
        @(negedge clk);
        sw_wr = 1'b1; sw_wr_entry = entry; sw_wr_style = style;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check("R1 straps_valid", straps_valid, 0);
        check("R1 fs_code", fs_code, 0);
        check("R1 role_latched", role_latched, 0);
        check("R1 cpu_freq", cpu_freq, 0);
        check("R1 reserved_code", reserved_code, 0);
        check("R1 test_active", test_active, 0);
        check("R1 test_by_hw", test_by_hw, 0);
        check("R1 out_mode", out_mode, 0);
        check("R1 refn_clk", refn_clk, 0);
    endtask

    task automatic t_decode();
        for (int c = 0; c < 8; c++) begin
            do_reset();
            capture(3'(c), 1'b0, c[0]);
            check("R2 straps_valid", straps_valid, 1);
            check("R2 fs_code", fs_code, c);
            check("R10 role_latched", role_latched, c & 1);
            check(c == 7 ? "R4 cpu_freq" : "R3 cpu_freq", cpu_freq, exp_cpu(c));
            check("R4 reserved_code", reserved_code, c == 7 ? 1 : 0);
            check("R3 src_freq", src_freq, 10000);
            check("R3 pci_freq", pci_freq, 3333);
            check("R1 no test after normal capture", test_active, 0);
        end
    endtask

    task automatic t_hold();
        do_reset();
        capture(3'b010, 1'b0, 1'b1);
        @(negedge clk);
        {fs_c_in, fs_b_in, fs_a_in} = 3'b101; fs_c_hi = 1'b1; role_strap = 1'b0; pwrgd_n = 1'b1;
        repeat (3) @(negedge clk);
        pwrgd_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 code held", fs_code, 2);
        check("R2 cpu held", cpu_freq, 20000);
        check("R10 role held", role_latched, 1);
        check("R2 late hi flag ignored", test_active, 0);
    endtask

    task automatic t_hw_test();
        do_reset();
        test_pin = 1'b0;
        capture(3'b110, 1'b1, 1'b0);
        check("R5 test_active", test_active, 1);
        check("R5 test_by_hw", test_by_hw, 1);
        check("R5 fs_code top bit cleared", fs_code, 2);
        check("R5 cpu from low bits", cpu_freq, 20000);
        check("R6 pin 0 high-Z", out_mode, 1);
        test_pin = 1'b1;
        @(negedge clk);
        check("R6 pin 1 REF/N", out_mode, 2);
        test_pin = 1'b0;
        sw_write(1'b0, 1'b1);
        check("R6 sw style ignored", out_mode, 1);
        test_pin = 1'b1;
        sw_write(1'b1, 1'b0);
        @(negedge clk);
        check("R7 sw takes over from pin", out_mode, 1);
    endtask

    task automatic t_sw_test();
        do_reset();
        capture(3'b000, 1'b0, 1'b0);
        check("R7 normal before write", out_mode, 0);
        sw_write(1'b1, 1'b0);
        check("R7 test_active", test_active, 1);
        check("R7 not by hw", test_by_hw, 0);
        check("R7 style 0 high-Z", out_mode, 1);
        test_pin = 1'b1;
        @(negedge clk);
        check("R7 pin ignored", out_mode, 1);
        sw_write(1'b0, 1'b1);
        check("R8 entry 0 does not clear", test_active, 1);
        check("R7 style 1 REF/N", out_mode, 2);
        pwrgd_n = 1'b1;
        repeat (2) @(negedge clk);
        pwrgd_n = 1'b0;
        @(negedge clk);
        check("R8 power-good toggle keeps test", test_active, 1);
        check("R8 mode kept", out_mode, 2);
        do_reset();
        @(negedge clk);
        check("R8 reset exits test", test_active, 0);
        check("R8 reset mode normal", out_mode, 0);
    endtask

    task automatic t_refn();
        int highs = 0;
        int last_rise = -1;
        int bad_gap = 0;
        logic prev = 1'b0;
        do_reset();
        capture(3'b001, 1'b0, 1'b0);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            if (refn_clk) highs++;
        end
        check("R9 no REF/N in normal", highs, 0);
        sw_write(1'b1, 1'b1);
        repeat (3) @(negedge clk);
        highs = 0;
        prev = refn_clk;
        for (int i = 0; i < 4 * N; i++) begin
            @(negedge clk);
            if (refn_clk) highs++;
            if (refn_clk && !prev) begin
                if (last_rise >= 0 && i - last_rise != N) bad_gap = i - last_rise;
                last_rise = i;
            end
            prev = refn_clk;
        end
        check("R9 high cycles in 4 periods", highs, 4 * (N / 2));
        check("R9 rise spacing error", bad_gap, 0);
        sw_write(1'b0, 1'b0);
        highs = 0;
        for (int i = 0; i < N; i++) begin
            if (refn_clk) highs++;
            @(negedge clk);
        end
        check("R9 silent in high-Z", highs, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_decode();
        t_hold();
        t_hw_test();
        t_sw_test();
        t_refn();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule